// File: doc/BRIEF.md
# Dual-Channel DAC Serial Register Interface

This block is the digital front end of a two-channel voltage DAC. A host writes 16-bit words over a framed three-wire serial port. The port has an active-low frame select, a serial clock and a data line. All three are sampled in the block's own system clock through two-flop synchronisers, and the serial clock's edges are found after synchronisation. When exactly sixteen falling serial-clock edges have been seen inside one frame, the word is decoded. It carries a channel select, a reference-buffer enable, a two-bit power-down mode and a code.

Each channel is double buffered. A write lands only in the addressed channel's staging register, so the analog output does not move. A separate active-low load strobe then copies both staging registers into the two output code registers in the same cycle. A host can therefore prepare both channels and update them together. The reference-buffer flag and the power-down mode of the addressed channel take effect as soon as the word is accepted.

The resolution is a parameter (8, 10 or 12 bits). The code field is left-justified, so narrower builds drop the low bits of the field.

Top module: `dual_dac_ctrl`

## Requirements
- R1: After reset, both output codes, both staging codes, both reference-buffer flags and both power-down modes are zero.
- R2: A word is shifted in most significant bit first. Bit 15 selects the channel (0 = A, 1 = B), bit 14 is the reference-buffer enable, bits 13:12 are the power-down mode (00 = normal) and bits 11:0 are the code field. The channel's code is the top RES_W bits of that field, bits 11 down to 12-RES_W.
- R3: If frame select rises before the 16th falling serial-clock edge of a frame, the word is dropped and no register changes.
- R4: The word is accepted once, on the 16th falling edge. Further falling edges in the same frame have no effect.
- R5: An accepted word changes only the staging code of the addressed channel, and the output codes stay unchanged until a load.
- R6: A falling edge of the load strobe copies both staging codes into both output codes in the same cycle.
- R7: An accepted word sets the addressed channel's reference-buffer flag and power-down mode from bits 14 and 13:12. The other channel's flag and mode are left unchanged.
- R8: Serial-clock edges while frame select is high shift nothing and accept no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | Active-low frame select from the host, asynchronous |
| ser_clk | input | 1 | Serial clock, data taken on its falling edge, asynchronous |
| ser_din | input | 1 | Serial data, MSB first, asynchronous |
| load_n | input | 1 | Active-low load strobe, asynchronous |
| dac_code_a | output | RES_W | Output code register of channel A |
| dac_code_b | output | RES_W | Output code register of channel B |
| ref_buf | output | 2 | Reference-buffer enable, bit 0 channel A, bit 1 channel B |
| pd_mode_a | output | 2 | Power-down mode of channel A (00 = normal) |
| pd_mode_b | output | 2 | Power-down mode of channel B (00 = normal) |

## Verification
The bench builds the block with RES_W set to 10 rather than the default 12. With that setting the left-justified extraction is visible: the two lowest bits of the code field must be dropped and bit 11 must land in the output MSB. The synchroniser depth stays at two. The serial clock is run at one sixth of the system clock, which keeps every frame, aborted frame and over-long frame well inside the synchroniser's reach.

// File: rtl/dacif_pkg.sv
// Shared types for the dual DAC serial interface.
// Assumes a fixed 16-bit host word; resolution is chosen at the top.
package dacif_pkg;

    localparam int WORD_W  = 16;
    localparam int FIELD_W = 12;

    // Output load condition while a channel is powered down.
    typedef enum logic [1:0] {
        PD_NORMAL = 2'b00,
        PD_LOAD_L = 2'b01,
        PD_LOAD_H = 2'b10,
        PD_FLOAT  = 2'b11
    } pd_mode_e;

    // Decoded host word, MSB first as received.
    typedef struct packed {
        logic               ch_sel;
        logic               ref_buf;
        pd_mode_e           pd;
        logic [FIELD_W-1:0] code;
    } ctl_word_t;

endpackage

// File: rtl/dacif_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous single-bit inputs.
// Assumes the bits are independent; each bit gets its own flop chain.
module dacif_sync #(
    parameter int             W       = 4,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] st [STAGES];

    // First stage captures the raw asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) st[0] <= RST_VAL;
        else        st[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        // Each further stage resamples the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) st[g] <= RST_VAL;
            else        st[g] <= st[g-1];
        end
    end

    assign q = st[STAGES-1];

endmodule

// File: rtl/dacif_shifter.sv
// Frame-based serial shift register.
// Counts falling serial-clock edges while the frame is active, shifts data
// MSB first, and emits a one-cycle valid with the word on the final edge.
// Assumes all inputs are already synchronised to clk.
module dacif_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n_s,
    input  logic              sclk_s,
    input  logic              din_s,
    output logic              word_vld,
    output logic [WORD_W-1:0] word
);

    localparam int            CNT_W  = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

    logic              sclk_q;
    logic              fall;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] shreg;

    assign fall = sclk_q & ~sclk_s;

    // Edge tracking, bit counting, shifting and word commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q   <= 1'b1;
            cnt      <= '0;
            shreg    <= '0;
            word_vld <= 1'b0;
            word     <= '0;
        end else begin
            sclk_q   <= sclk_s;
            word_vld <= 1'b0;
            if (frame_n_s) begin
                cnt <= '0;
            end else if (fall && (cnt != CNT_FULL)) begin
                shreg <= {shreg[WORD_W-2:0], din_s};
                cnt   <= cnt + 1'b1;
                if (cnt == CNT_LAST) begin
                    word_vld <= 1'b1;
                    word     <= {shreg[WORD_W-2:0], din_s};
                end
            end
        end
    end

    AST_NO_COMMIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_n_s |=> !word_vld);                                   // R3
    AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);                                    // R4
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_FULL);                                           // R4

endmodule

// File: rtl/dacif_chan.sv
// One DAC channel: staging code, output code, reference-buffer flag and
// power-down mode. Accepts a decoded word when it addresses CH_ID and
// transfers staging to output on the shared load pulse.
module dacif_chan
    import dacif_pkg::*;
#(
    parameter int   RES_W = 12,
    parameter logic CH_ID = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_vld,
    input  ctl_word_t        ctl,
    input  logic             load,
    output logic [RES_W-1:0] dac_code,
    output logic             ref_buf,
    output pd_mode_e         pd
);

    logic             wr_en;
    logic [RES_W-1:0] stage_code;
    logic [RES_W-1:0] new_code;

    assign wr_en    = wr_vld && (ctl.ch_sel == CH_ID);
    assign new_code = ctl.code[FIELD_W-1 -: RES_W];

    // Staging register and control fields, written by an addressed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_code <= '0;
            ref_buf    <= 1'b0;
            pd         <= PD_NORMAL;
        end else if (wr_en) begin
            stage_code <= new_code;
            ref_buf    <= ctl.ref_buf;
            pd         <= ctl.pd;
        end
    end

    // Output code register, loaded from staging on the shared strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    dac_code <= '0;
        else if (load) dac_code <= stage_code;
    end

    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(stage_code));                            // R5
    AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(dac_code));                               // R5
    AST_DAC_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (dac_code == $past(stage_code)));                  // R6
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(ref_buf) && $stable(pd)));              // R7

endmodule

// File: rtl/dual_dac_ctrl.sv
// Top of the dual DAC serial register interface.
// Synchronises the host pins, assembles 16-bit frames, decodes them and
// drives two double-buffered channels with a shared load strobe.
// Assumes the serial clock is well below a third of clk.
module dual_dac_ctrl
    import dacif_pkg::*;
#(
    parameter int RES_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n,
    input  logic             ser_clk,
    input  logic             ser_din,
    input  logic             load_n,
    output logic [RES_W-1:0] dac_code_a,
    output logic [RES_W-1:0] dac_code_b,
    output logic [1:0]       ref_buf,
    output logic [1:0]       pd_mode_a,
    output logic [1:0]       pd_mode_b
);

    localparam int NUM_CH = 2;

    logic [3:0]        pins_s;
    logic              load_n_s, frame_n_s, sclk_s, din_s;
    logic              load_n_q;
    logic              load_pulse;
    logic              word_vld;
    logic [WORD_W-1:0] word;
    ctl_word_t         ctl;

    logic [RES_W-1:0]  code_arr [NUM_CH];
    logic [NUM_CH-1:0] buf_arr;
    pd_mode_e          pd_arr   [NUM_CH];

    dacif_sync #(
        .W       (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1110)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({load_n, frame_n, ser_clk, ser_din}),
        .q     (pins_s)
    );

    assign {load_n_s, frame_n_s, sclk_s, din_s} = pins_s;

    // Falling-edge detector for the synchronised load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) load_n_q <= 1'b1;
        else        load_n_q <= load_n_s;
    end

    assign load_pulse = load_n_q & ~load_n_s;

    dacif_shifter #(
        .WORD_W (WORD_W)
    ) i_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n_s (frame_n_s),
        .sclk_s    (sclk_s),
        .din_s     (din_s),
        .word_vld  (word_vld),
        .word      (word)
    );

    assign ctl = ctl_word_t'(word);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dacif_chan #(
            .RES_W (RES_W),
            .CH_ID (1'(c))
        ) i_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_vld   (word_vld),
            .ctl      (ctl),
            .load     (load_pulse),
            .dac_code (code_arr[c]),
            .ref_buf  (buf_arr[c]),
            .pd       (pd_arr[c])
        );
    end

    assign dac_code_a = code_arr[0];
    assign dac_code_b = code_arr[1];
    assign ref_buf    = buf_arr;
    assign pd_mode_a  = pd_arr[0];
    assign pd_mode_b  = pd_arr[1];

    AST_LOAD_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |=> !load_pulse);                                // R6
    AST_OUT_STABLE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_pulse |=> ($stable(dac_code_a) && $stable(dac_code_b))); // R5

endmodule

// File: tb/test_dual_dac_ctrl.sv
// Directed bench for dual_dac_ctrl, built with a 10-bit resolution.
module test_dual_dac_ctrl;

    localparam int RES = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           frame_n = 1'b1;
    logic           ser_clk = 1'b1;
    logic           ser_din = 1'b0;
    logic           load_n = 1'b1;
    logic [RES-1:0] dac_code_a, dac_code_b;
    logic [1:0]     ref_buf, pd_mode_a, pd_mode_b;

    int checks = 0;
    int fails  = 0;

    // Expected state, kept from the requirements.
    logic [RES-1:0] m_stage [2];
    logic [RES-1:0] m_dac   [2];
    logic           m_buf   [2];
    logic [1:0]     m_pd    [2];

    always #5 clk = ~clk;

    dual_dac_ctrl #(.RES_W(RES), .SYNC_STAGES(2)) i_dual_dac_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_n    (frame_n),
        .ser_clk    (ser_clk),
        .ser_din    (ser_din),
        .load_n     (load_n),
        .dac_code_a (dac_code_a),
        .dac_code_b (dac_code_b),
        .ref_buf    (ref_buf),
        .pd_mode_a  (pd_mode_a),
        .pd_mode_b  (pd_mode_b)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, 32'(dac_code_a), 32'(m_dac[0]));
        chk(req, 32'(dac_code_b), 32'(m_dac[1]));
        chk(req, 32'(ref_buf),    {30'd0, m_buf[1], m_buf[0]});
        chk(req, 32'(pd_mode_a),  32'(m_pd[0]));
        chk(req, 32'(pd_mode_b),  32'(m_pd[1]));
    endtask

    // Frame of nbits falling edges; bits past 16 are driven high.
    task automatic send(input logic [15:0] w, input int nbits);
        frame_n = 1'b0;
        wait_clk(3);
        for (int i = 0; i < nbits; i++) begin
            ser_din = (i < 16) ? w[15-i] : 1'b1;
            wait_clk(3);
            ser_clk = 1'b0;
            wait_clk(3);
            ser_clk = 1'b1;
        end
        wait_clk(3);
        frame_n = 1'b1;
        wait_clk(8);
        if (nbits >= 16) begin
            m_stage[w[15]] = w[11 -: RES];
            m_buf[w[15]]   = w[14];
            m_pd[w[15]]    = w[13:12];
        end
    endtask

    task automatic pulse_load;
        load_n = 1'b0;
        wait_clk(4);
        load_n = 1'b1;
        wait_clk(8);
        m_dac[0] = m_stage[0];
        m_dac[1] = m_stage[1];
    endtask

    task automatic t_reset;
        chk_all("R1");
    endtask

    task automatic t_stage_then_load;
        send({1'b0, 1'b1, 2'b00, 12'h5A4}, 16);
        chk_all("R5");               // output A still zero
        chk_all("R7");               // buffer flag A set
        send({1'b1, 1'b0, 2'b00, 12'h3C8}, 16);
        chk("R5", 32'(dac_code_b), 32'h0);
        pulse_load;
        chk("R6", 32'(dac_code_a), 32'(12'h5A4 >> 2));
        chk("R6", 32'(dac_code_b), 32'(12'h3C8 >> 2));
    endtask

    task automatic t_short_frame;
        send({1'b0, 1'b0, 2'b11, 12'hFFF}, 10);
        chk_all("R3");
        pulse_load;
        chk_all("R3");
    endtask

    task automatic t_long_frame;
        send({1'b0, 1'b1, 2'b00, 12'h124}, 24);
        pulse_load;
        chk("R4", 32'(dac_code_a), 32'(12'h124 >> 2));
        chk_all("R4");
    endtask

    task automatic t_justify;
        send({1'b0, 1'b1, 2'b00, 12'hABF}, 16);
        pulse_load;
        chk("R2", 32'(dac_code_a), 32'h2AF);
        send({1'b1, 1'b0, 2'b00, 12'h803}, 16);
        pulse_load;
        chk("R2", 32'(dac_code_b), 32'h200);
    endtask

    task automatic t_ctrl_fields;
        send({1'b1, 1'b1, 2'b11, 12'h000}, 16);
        chk("R7", 32'(pd_mode_b), 32'h3);
        chk("R7", 32'(pd_mode_a), 32'h0);
        chk("R7", 32'(ref_buf), {30'd0, 1'b1, m_buf[0]});
        send({1'b0, 1'b0, 2'b10, 12'h000}, 16);
        chk("R7", 32'(pd_mode_a), 32'h2);
        chk("R7", 32'(pd_mode_b), 32'h3);
        chk_all("R7");
    endtask

    task automatic t_idle_clocks;
        for (int i = 0; i < 20; i++) begin
            ser_din = i[0];
            wait_clk(3);
            ser_clk = 1'b0;
            wait_clk(3);
            ser_clk = 1'b1;
        end
        wait_clk(8);
        chk_all("R8");
        pulse_load;
        chk_all("R8");
    endtask

    initial begin
        for (int c = 0; c < 2; c++) begin
            m_stage[c] = '0; m_dac[c] = '0; m_buf[c] = 1'b0; m_pd[c] = 2'b00;
        end
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        t_reset;
        t_stage_then_load;
        t_short_frame;
        t_long_frame;
        t_justify;
        t_ctrl_fields;
        t_idle_clocks;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule